// File: doc/BRIEF.md
# Posted CAS Additive Latency Pipeline

This block is the command timing unit on the device side of a DDR2-style memory model. A command decoder hands it ACTIVE, READ, WRITE and NOP codes, one per clock. Each READ or WRITE is held for a programmable additive latency (AL) before an internal issue strobe fires. Once the command has been accepted, the block opens a read-data window at the read latency, which is AL plus the CAS latency (CL). A write-data window opens one clock earlier than the read latency would be. Each window lasts one burst, which is four clocks for a burst length of four. Several commands can be in flight at the same time, and they leave in the order they arrived.

A mode load port writes two fields. With the extended select set, the port writes the additive latency and a termination enable. With the select clear, it writes the CAS latency. An encoding outside the legal range raises an error pulse and is discarded. When a READ or WRITE arrives too soon after ACTIVE to meet the row-to-column delay, even with the additive latency counted in, the block raises a timing-violation pulse. The on-die-termination request from outside passes through only when termination is enabled and a fixed settling period has run out since the last write that enabled termination.

Timing convention: a command is captured on rising edge T0. An output that is "at k" is high during the clock period that follows edge Tk.

Top module: `al_cmd_pipe`

## Requirements
- R1: An extended load (mr_load=1, mr_ext=1) with mr_data[5:3] in 0..4 sets AL to that binary value. Reset sets AL to 0.
- R2: An extended load with mr_data[5:3] in 5..7 raises mr_err for the one period after the load edge and changes neither AL nor the termination enable. A legal load leaves mr_err low.
- R3: A normal load (mr_load=1, mr_ext=0) with mr_data[6:4] in 3..5 sets CL. Reset sets CL to 3. Values 0..2, 6 and 7 raise mr_err for one period and leave CL unchanged.
- R4: The command codes are 2'b00 NOP, 2'b01 ACTIVE, 2'b10 READ and 2'b11 WRITE. A READ or WRITE captured at T0 pulses rd_issue or wr_issue for a single period, at AL.
- R5: A READ captured at T0 holds rd_window high from AL+CL through AL+CL+3.
- R6: A WRITE captured at T0 holds wr_window high from AL+CL-1 through AL+CL+2.
- R7: Commands spaced two clocks apart are all carried, in order. Their issue strobes are two clocks apart and their windows join into one continuous window.
- R8: A READ or WRITE that arrives d clocks after the latest ACTIVE, with d+AL < TRCD (TRCD defaults to 5), raises timing_err for the one period after its capture edge. When d+AL >= TRCD, timing_err stays low.
- R9: mr_data[2] of an extended load is the termination enable. odt_en equals odt_in while termination is enabled and no settling is pending. A legal extended load that sets the enable blocks odt_en for periods 0..7 after its edge, and odt_in passes from period 8 on. While the enable is clear, odt_en is 0.
- R10: Reset discards every pending command, so no strobe or window follows it. It also clears the termination enable, so odt_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Command code: NOP, ACTIVE, READ, WRITE |
| mr_load | input | 1 | Mode load strobe |
| mr_ext | input | 1 | Selects the extended field (AL, termination) rather than CL |
| mr_data | input | 8 | Mode value: AL in [5:3], termination enable in [2], CL in [6:4] |
| odt_in | input | 1 | External termination request |
| rd_issue | output | 1 | Internal READ issue strobe |
| wr_issue | output | 1 | Internal WRITE issue strobe |
| rd_window | output | 1 | Read-data burst window |
| wr_window | output | 1 | Write-data burst window |
| odt_en | output | 1 | Gated termination enable |
| mr_err | output | 1 | Reserved-encoding error pulse |
| timing_err | output | 1 | Row-to-column timing violation pulse |

## Verification
The bench measures when the strobe and the window start, and how long each lasts, for all fifteen AL and CL pairs, for both reads and writes. A design that adds a pipeline register, or that skips the write-latency offset, shows up as a start cycle one off. Reserved AL and CL writes are each followed by a timing measurement, so a design that flags the bad value but adopts it anyway shows the wrong delay. Three further cases are covered:
- Reads spaced two clocks apart at the largest latency. Dropped or merged commands show up as missing strobes or a gap in the window.
- A reset taken mid-flight, which must leave no burst behind it.
- The edge of the termination settling period. An off-by-one counter opens termination at the wrong period.

// File: rtl/al_cmd_pipe.sv
module al_cmd_pipe #(
  parameter int BL         = 4,
  parameter int TRCD       = 5,
  parameter int ODT_SETTLE = 8,
  parameter int AL_MAX     = 4,
  parameter int CL_MIN     = 3,
  parameter int CL_MAX     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd,
  input  logic       mr_load,
  input  logic       mr_ext,
  input  logic [7:0] mr_data,
  input  logic       odt_in,
  output logic       rd_issue,
  output logic       wr_issue,
  output logic       rd_window,
  output logic       wr_window,
  output logic       odt_en,
  output logic       mr_err,
  output logic       timing_err
);
  localparam int DEPTH = AL_MAX + CL_MAX + BL;
  localparam int AW    = $clog2(TRCD + 1);
  localparam int SW    = $clog2(ODT_SETTLE + 1);
  localparam logic [1:0] C_ACT = 2'b01, C_RD = 2'b10, C_WR = 2'b11;

  logic [2:0]       al_q, cl_q;
  logic             term_q;
  logic [DEPTH-1:0] rd_h, wr_h;
  logic [AW-1:0]    act_age;
  logic [SW-1:0]    settle;
  logic [4:0]       rl, wl;

  wire is_rw  = (cmd == C_RD) || (cmd == C_WR);
  wire al_ok  = int'(mr_data[5:3]) <= AL_MAX;
  wire cl_ok  = int'(mr_data[6:4]) >= CL_MIN && int'(mr_data[6:4]) <= CL_MAX;
  wire ext_ok = mr_load && mr_ext && al_ok;
  wire early  = is_rw && (int'(act_age) + int'(al_q) + 1 < TRCD);
  wire unused_bits = &{1'b0, mr_data[7], mr_data[1:0]};

  assign rl       = 5'(al_q) + 5'(cl_q);
  assign wl       = rl - 5'd1;
  assign rd_issue = rd_h[al_q];
  assign wr_issue = wr_h[al_q];
  assign odt_en   = odt_in && term_q && (settle == '0);

  always_comb begin
    rd_window = 1'b0;
    wr_window = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_h[i] && i >= int'(rl) && i < int'(rl) + BL) rd_window = 1'b1;
      if (wr_h[i] && i >= int'(wl) && i < int'(wl) + BL) wr_window = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q       <= 3'd0;
      cl_q       <= 3'(CL_MIN);
      term_q     <= 1'b0;
      mr_err     <= 1'b0;
      settle     <= '0;
    end else begin
      mr_err <= mr_load && (mr_ext ? !al_ok : !cl_ok);
      if (ext_ok) begin
        al_q   <= mr_data[5:3];
        term_q <= mr_data[2];
      end
      if (mr_load && !mr_ext && cl_ok) cl_q <= mr_data[6:4];
      if (ext_ok && mr_data[2])  settle <= SW'(ODT_SETTLE);
      else if (settle != '0)     settle <= settle - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_h       <= '0;
      wr_h       <= '0;
      act_age    <= AW'(TRCD);
      timing_err <= 1'b0;
    end else begin
      rd_h       <= {rd_h[DEPTH-2:0], cmd == C_RD};
      wr_h       <= {wr_h[DEPTH-2:0], cmd == C_WR};
      timing_err <= early;
      if (cmd == C_ACT)                act_age <= '0;
      else if (int'(act_age) < TRCD)   act_age <= act_age + 1'b1;
    end
  end
endmodule

// File: rtl/al_cmd_pipe_chk.sv
module al_cmd_pipe_chk #(parameter int TRCD = 5) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd,
  input logic       mr_load,
  input logic       mr_ext,
  input logic [7:0] mr_data,
  input logic [2:0] al_q,
  input logic [2:0] cl_q,
  input logic       rd_issue,
  input logic       odt_en,
  input logic       mr_err,
  input logic       timing_err
);
  a_r2_reserved_al_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_load && mr_ext && mr_data[5:3] > 3'd4) |=> (mr_err && al_q == $past(al_q)));

  a_r3_reserved_cl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_load && !mr_ext && (mr_data[6:4] < 3'd3 || mr_data[6:4] > 3'd5))
      |=> (mr_err && cl_q == $past(cl_q)));

  a_r4_zero_al_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b10 && al_q == 3'd0 && !(mr_load && mr_ext)) |=> rd_issue);

  a_r8_early_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[1] && $past(cmd) == 2'b01 && int'(al_q) + 1 < TRCD && !(mr_load && mr_ext))
      |=> timing_err);

  a_r9_odt_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_load && mr_ext && mr_data[5:3] <= 3'd4 && mr_data[2]) |=> !odt_en);
endmodule

bind al_cmd_pipe al_cmd_pipe_chk #(.TRCD(TRCD)) chk (.*);

// File: tb/sim_al_cmd_pipe.sv
`timescale 1ns/1ps
module sim_al_cmd_pipe;
  logic clk = 0, rst_n = 0;
  logic [1:0] cmd = 2'b00;
  logic mr_load = 0, mr_ext = 0, odt_in = 0;
  logic [7:0] mr_data = 8'h00;
  logic rd_issue, wr_issue, rd_window, wr_window, odt_en, mr_err, timing_err;
  int checks = 0, errors = 0;

  al_cmd_pipe u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(logic ext, logic [7:0] d);
    @(negedge clk);
    mr_load = 1; mr_ext = ext; mr_data = d;
    @(posedge clk);
    @(negedge clk);
    mr_load = 0;
  endtask

  task automatic send(logic [1:0] c);
    @(negedge clk);
    cmd = c;
    @(posedge clk);
  endtask

  task automatic measure(logic [1:0] c, int span, output int iss_first, output int iss_cnt,
                         output int win_first, output int win_cnt);
    iss_first = -1; iss_cnt = 0; win_first = -1; win_cnt = 0;
    send(c);
    for (int j = 0; j < span; j++) begin
      @(negedge clk);
      cmd = 2'b00;
      if (c == 2'b10 ? rd_issue : wr_issue) begin
        if (iss_first < 0) iss_first = j;
        iss_cnt++;
      end
      if (c == 2'b10 ? rd_window : wr_window) begin
        if (win_first < 0) win_first = j;
        win_cnt++;
      end
    end
  endtask

  task automatic t_reset_state;
    odt_in = 1;
    @(negedge clk);
    chk("R10 reset rd_window", rd_window, 0);
    chk("R10 reset odt_en", odt_en, 0);
    chk("R10 reset issue", rd_issue | wr_issue, 0);
    chk("R2 reset mr_err", mr_err, 0);
    odt_in = 0;
  endtask

  task automatic t_default_latency;
    int f, n, wf, wn;
    measure(2'b10, 16, f, n, wf, wn);
    chk("R1 default AL issue", f, 0);
    chk("R3 default CL read start", wf, 3);
  endtask

  task automatic t_sweep;
    int f, n, wf, wn;
    for (int al = 0; al <= 4; al++) begin
      for (int cl = 3; cl <= 5; cl++) begin
        load(1, 8'((al << 3)));
        load(0, 8'((cl << 4)));
        idle(2);
        measure(2'b10, 16, f, n, wf, wn);
        chk($sformatf("R4 rd issue al%0d cl%0d", al, cl), f, al);
        chk("R4 rd issue count", n, 1);
        chk($sformatf("R5 rd start al%0d cl%0d", al, cl), wf, al + cl);
        chk("R5 rd length", wn, 4);
        measure(2'b11, 16, f, n, wf, wn);
        chk($sformatf("R4 wr issue al%0d cl%0d", al, cl), f, al);
        chk($sformatf("R6 wr start al%0d cl%0d", al, cl), wf, al + cl - 1);
        chk("R6 wr length", wn, 4);
      end
    end
  endtask

  task automatic t_reserved;
    int f, n, wf, wn;
    load(1, 8'(1 << 3));
    load(0, 8'(4 << 4));
    @(negedge clk); mr_load = 1; mr_ext = 1; mr_data = 8'(6 << 3);
    @(posedge clk); @(negedge clk); mr_load = 0;
    chk("R2 reserved AL flag", mr_err, 1);
    @(negedge clk);
    chk("R2 flag one period", mr_err, 0);
    @(negedge clk); mr_load = 1; mr_ext = 0; mr_data = 8'(6 << 4);
    @(posedge clk); @(negedge clk); mr_load = 0;
    chk("R3 reserved CL flag", mr_err, 1);
    @(negedge clk); mr_load = 1; mr_ext = 0; mr_data = 8'(2 << 4);
    @(posedge clk); @(negedge clk); mr_load = 0;
    chk("R3 reserved CL low flag", mr_err, 1);
    idle(2);
    measure(2'b10, 16, f, n, wf, wn);
    chk("R2 AL kept after reserved", f, 1);
    chk("R3 CL kept after reserved", wf, 5);
    @(negedge clk); mr_load = 1; mr_ext = 1; mr_data = 8'(2 << 3);
    @(posedge clk); @(negedge clk); mr_load = 0;
    chk("R2 legal write no flag", mr_err, 0);
  endtask

  task automatic t_back_to_back;
    int iss[$];
    int win = 0, wfirst = -1;
    load(1, 8'(4 << 3));
    load(0, 8'(5 << 4));
    idle(2);
    for (int j = -1; j < 22; j++) begin
      @(negedge clk);
      cmd = (j == -1 || j == 1 || j == 3) ? 2'b10 : 2'b00;
      if (j >= 0) begin
        if (rd_issue) iss.push_back(j);
        if (rd_window) begin win++; if (wfirst < 0) wfirst = j; end
      end
    end
    chk("R7 issue count", iss.size(), 3);
    if (iss.size() == 3) begin
      chk("R7 issue order 0", iss[0], 4);
      chk("R7 issue order 1", iss[1], 6);
      chk("R7 issue order 2", iss[2], 8);
    end
    chk("R7 merged window start", wfirst, 9);
    chk("R7 merged window length", win, 8);
  endtask

  task automatic t_timing(int al, int d, int exp);
    load(1, 8'(al << 3));
    idle(6);
    send(2'b01);
    for (int i = 1; i < d; i++) send(2'b00);
    send(2'b10);
    @(negedge clk);
    cmd = 2'b00;
    chk($sformatf("R8 timing al%0d d%0d", al, d), timing_err, exp);
    idle(16);
  endtask

  task automatic t_odt;
    int first = -1, cnt = 0;
    odt_in = 1;
    @(negedge clk); mr_load = 1; mr_ext = 1; mr_data = 8'h04;
    @(posedge clk);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      mr_load = 0;
      if (odt_en) begin cnt++; if (first < 0) first = j; end
    end
    chk("R9 odt opens at 8", first, 8);
    chk("R9 odt high count", cnt, 2);
    odt_in = 0;
    @(negedge clk);
    chk("R9 odt follows input", odt_en, 0);
    odt_in = 1;
    load(1, 8'h00);
    idle(10);
    chk("R9 odt off when disabled", odt_en, 0);
    odt_in = 0;
  endtask

  task automatic t_reset_flight;
    int any = 0, f, n, wf, wn;
    load(1, 8'(4 << 3));
    load(0, 8'(5 << 4));
    send(2'b10);
    @(negedge clk); cmd = 2'b00;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int j = 0; j < 16; j++) begin
      @(negedge clk);
      any |= rd_issue | rd_window;
    end
    chk("R10 pending cleared", any, 0);
    measure(2'b10, 16, f, n, wf, wn);
    chk("R10 AL cleared", f, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_default_latency();
    t_sweep();
    t_reserved();
    t_back_to_back();
    t_timing(0, 2, 1);
    t_timing(3, 2, 0);
    t_timing(2, 2, 1);
    t_timing(4, 1, 0);
    t_odt();
    t_reset_flight();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule